// File: doc/BRIEF.md
# Rolling Four-Activate Window Limiter

This block sits in the command path of a DRAM controller. It decides whether a row-activate may go out in the current cycle. The rule is that no span of `win_len` consecutive clocks may hold more than four activates. The limit covers every bank together, because a part with eight internal banks has to stay inside its instantaneous supply-current budget.

Software or a timing table converts the window from nanoseconds to clocks before it reaches the block: the window in ns is divided by the average clock period and rounded up.

The scheduler raises `act_req` whenever it has an activate ready. The block answers in the same cycle:
- `act_ok` shows whether an activate would be legal right now.
- `act_fire` marks that the activate was actually taken.

Internally the block records the cycle stamp of each of the last four activates taken. It compares the oldest of these stamps with a free-running cycle count. Stamps that are too old to matter are retired, so a long idle period can never be mistaken for a recent burst.

Top module: `faw_act_limiter`

## Requirements
- R1: No run of `win_len` consecutive cycles contains more than four cycles with `act_fire` high.
- R2: When four activates fire back to back starting in cycle N, with `win_len` = W ≥ 4, `act_ok` is low in cycles N+4 through N+W-1 and high again in cycle N+W.
- R3: `act_ok` is combinational from the recorded history and `win_len`. `act_fire` is high exactly in the cycles where `act_req` and `act_ok` are both high, and it is low whenever `act_req` is low.
- R4: `act_ok` is high whenever fewer than four activates fired in the previous `win_len`-1 cycles.
- R5: The reset is synchronous and active low (`rst_n` = 0). It clears the history, so `act_ok` is high during reset once a clock edge has passed. It is also high in the first cycle after release, whatever the history was before.
- R6: A change of `win_len` applies to the permission check of the same cycle. The activates already recorded stay recorded.
- R7: With `win_len` = 1 the block never withholds an activate, even when `act_req` is held high continuously.
- R8: An activate that fired 63 or more cycles ago never holds off a new one, however long the idle period, including after the internal cycle count wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_req | input | 1 | Scheduler has an activate ready this cycle |
| win_len | input | 6 | Window length in clocks, 1 to 63 |
| act_ok | output | 1 | An activate is legal in this cycle |
| act_fire | output | 1 | Activate taken in this cycle |

## Verification
The bench builds the block with its default values: four activates per window and a 6-bit window field. With these values every window length from 1 to 63 can be reached, and so can the 7-bit internal stamp counter wrapping during an idle period.

A window of 6 is used for the dense back-to-back pattern. Windows of 20 and 5 show a length change while four activates are held in the history. A window of 63 drives the oldest stamp to its retirement point and then keeps the block idle across several counter wraps.

// File: rtl/faw_pkg.sv
// Package faw_pkg
// Shared constants for the rolling activate-window limiter.
// Assumes the activate limit is a power of two, so the history pointer
// wraps naturally.
package faw_pkg;
    localparam int unsigned FAW_ACTS_DEF  = 4;
    localparam int unsigned FAW_WIN_W_DEF = 6;
endpackage

// File: rtl/faw_stamp_counter.sv
// Module faw_stamp_counter
// Free-running cycle counter that supplies the stamps for issued activates.
// Assumes that users compare stamps only by modular subtraction.
module faw_stamp_counter #(
    parameter int unsigned STAMP_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [STAMP_W-1:0] now
);
    // Advance the cycle count by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end
endmodule

// File: rtl/faw_history.sv
// Module faw_history
// Circular store of the cycle stamps of the last ACTS issued activates.
// The write pointer always names the oldest slot. A slot retires (its valid
// bit clears) once its age reaches MAX_AGE, which keeps every live age below
// the stamp modulus.
// Assumes ACTS is a power of two and MAX_AGE < 2**STAMP_W.
module faw_history #(
    parameter int unsigned ACTS    = 4,
    parameter int unsigned STAMP_W = 7,
    parameter int unsigned MAX_AGE = 63
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [STAMP_W-1:0] now,
    output logic               oldest_valid,
    output logic [STAMP_W-1:0] oldest_stamp
);
    localparam int unsigned PTR_W = (ACTS > 1) ? $clog2(ACTS) : 1;

    logic [PTR_W-1:0]   wr_ptr;
    logic [STAMP_W-1:0] slot_stamp [ACTS];
    logic [ACTS-1:0]    slot_valid;

    // Step the oldest-slot pointer on every recorded activate.
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_ptr <= '0;
        else if (push) wr_ptr <= (wr_ptr == PTR_W'(ACTS-1)) ? '0 : wr_ptr + 1'b1;
    end

    for (genvar gi = 0; gi < ACTS; gi++) begin : g_slot
        logic [STAMP_W-1:0] age;
        logic               hit;
        assign age = now - slot_stamp[gi];
        assign hit = push && (wr_ptr == PTR_W'(gi));

        // Record a new stamp, or retire the slot once its age is too large to matter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_valid[gi] <= 1'b0;
                slot_stamp[gi] <= '0;
            end else if (hit) begin
                slot_valid[gi] <= 1'b1;
                slot_stamp[gi] <= now;
            end else if (slot_valid[gi] && age >= STAMP_W'(MAX_AGE)) begin
                slot_valid[gi] <= 1'b0;
            end
        end
    end

    // Present the slot that the next activate would overwrite.
    always_comb begin
        oldest_valid = slot_valid[wr_ptr];
        oldest_stamp = slot_stamp[wr_ptr];
    end
endmodule

// File: rtl/faw_window_check.sv
// Module faw_window_check
// Permission test: an activate is legal when the oldest recorded one is
// absent or is at least win_len cycles old.
// Assumes the history guarantees that a valid stamp is less than 2**STAMP_W old.
module faw_window_check #(
    parameter int unsigned WIN_W   = 6,
    parameter int unsigned STAMP_W = 7
) (
    input  logic               oldest_valid,
    input  logic [STAMP_W-1:0] oldest_stamp,
    input  logic [STAMP_W-1:0] now,
    input  logic [WIN_W-1:0]   win_len,
    output logic               allow
);
    logic [STAMP_W-1:0] elapsed;

    // Compare the age of the oldest activate with the programmed window.
    always_comb begin
        elapsed = now - oldest_stamp;
        allow   = !oldest_valid || (elapsed >= STAMP_W'(win_len));
    end
endmodule

// File: rtl/faw_act_limiter.sv
// Module faw_act_limiter (top)
// Grants row-activates so that at most ACTS fall within any rolling window of
// win_len clocks, counted across all banks. The grant is combinational, so a
// request and its grant share a cycle.
// Assumes win_len is held within 1 .. 2**WIN_W-1; a value of 0 never blocks.
module faw_act_limiter #(
    parameter int unsigned ACTS  = faw_pkg::FAW_ACTS_DEF,
    parameter int unsigned WIN_W = faw_pkg::FAW_WIN_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_req,
    input  logic [WIN_W-1:0] win_len,
    output logic             act_ok,
    output logic             act_fire
);
    localparam int unsigned STAMP_W = WIN_W + 1;
    localparam int unsigned MAX_AGE = (1 << WIN_W) - 1;

    logic [STAMP_W-1:0] now;
    logic               oldest_valid;
    logic [STAMP_W-1:0] oldest_stamp;
    logic               allow;

    faw_stamp_counter #(.STAMP_W(STAMP_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    faw_history #(.ACTS(ACTS), .STAMP_W(STAMP_W), .MAX_AGE(MAX_AGE)) u_hist (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (act_fire),
        .now          (now),
        .oldest_valid (oldest_valid),
        .oldest_stamp (oldest_stamp)
    );

    faw_window_check #(.WIN_W(WIN_W), .STAMP_W(STAMP_W)) u_chk (
        .oldest_valid (oldest_valid),
        .oldest_stamp (oldest_stamp),
        .now          (now),
        .win_len      (win_len),
        .allow        (allow)
    );

    // Drive the grant and the issue strobe from the permission test.
    always_comb begin
        act_ok   = allow;
        act_fire = act_req && allow;
    end
endmodule

// File: rtl/faw_act_limiter_chk.sv
// Module faw_act_limiter_chk
// Port-level checker. It keeps its own shift register of issue strobes and
// counts the activates inside the current window independently of the
// stamp history.
module faw_act_limiter_chk #(
    parameter int unsigned ACTS  = 4,
    parameter int unsigned WIN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act_req,
    input logic [WIN_W-1:0] win_len,
    input logic             act_ok,
    input logic             act_fire
);
    localparam int unsigned HIST = 1 << WIN_W;

    logic [HIST-1:0] fired;
    logic [HIST-1:0] mask;
    int unsigned     in_win;

    // Shift in one issue strobe per cycle; bit i is the strobe from i+1 cycles ago.
    always_ff @(posedge clk) begin
        if (!rst_n) fired <= '0;
        else        fired <= {fired[HIST-2:0], act_fire};
    end

    // Select the previous win_len-1 cycles and count the activates in them.
    always_comb begin
        mask = '0;
        for (int i = 0; i < HIST; i++) begin
            if (i + 1 < int'(win_len)) mask[i] = 1'b1;
        end
        in_win = $countones(fired & mask);
    end

    p_window_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> (in_win < ACTS));
    p_ok_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok == (in_win < ACTS));
    p_grant_same_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_req && act_ok) |-> act_fire);
    p_no_spurious_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> act_req);
    p_open_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> act_ok);
    p_unit_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_len == WIN_W'(1)) |-> act_ok);
endmodule

bind faw_act_limiter faw_act_limiter_chk #(.ACTS(ACTS), .WIN_W(WIN_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_req  (act_req),
    .win_len  (win_len),
    .act_ok   (act_ok),
    .act_fire (act_fire)
);

// File: tb/faw_act_limiter_tb_top.sv
`timescale 1ns/1ps
module faw_act_limiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_req = 1'b0;
    logic [5:0] win_len = 6'd6;
    logic       act_ok;
    logic       act_fire;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    faw_act_limiter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_req  (act_req),
        .win_len  (win_len),
        .act_ok   (act_ok),
        .act_fire (act_fire)
    );

    // Vector bits: [7] request, [6:1] window, [0] expected grant.
    // Pattern for R1/R2/R4 with a window of 6, starting right after reset.
    localparam logic [7:0] VEC [13] = '{
        {1'b1, 6'd6, 1'b1}, {1'b1, 6'd6, 1'b1}, {1'b1, 6'd6, 1'b1}, {1'b1, 6'd6, 1'b1},
        {1'b1, 6'd6, 1'b0}, {1'b1, 6'd6, 1'b0},
        {1'b1, 6'd6, 1'b1}, {1'b1, 6'd6, 1'b1}, {1'b1, 6'd6, 1'b1}, {1'b1, 6'd6, 1'b1},
        {1'b1, 6'd6, 1'b0}, {1'b0, 6'd6, 1'b0}, {1'b0, 6'd6, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, sample 1 ns later, then let the rising edge pass.
    task automatic step(input logic req, input logic [5:0] w, input logic exp_ok, input string tag);
        @(negedge clk);
        act_req = req;
        win_len = w;
        #1;
        check(act_ok, exp_ok, {tag, " ok"});
        check(act_fire, req & exp_ok, {tag, " fire (R3)"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        act_req = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(act_ok, 1'b1, "R5 ok in reset");
        check(act_fire, 1'b0, "R5 fire in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // Table walk: back-to-back activates with a window of 6.
        for (int i = 0; i < 13; i++) begin
            step(VEC[i][7], VEC[i][6:1], VEC[i][0], $sformatf("R2 vec%0d", i));
        end

        // R5: fill the history with a long window, then reset; the grant must open at once.
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b1, 6'd20, 1'b1, "R1 fill");
        step(1'b1, 6'd20, 1'b0, "R1 fifth held");
        do_reset();
        step(1'b1, 6'd20, 1'b1, "R5 first after release");

        // R6: four at cycles 0..3 with window 20; shortening to 5 frees cycle 5.
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b1, 6'd20, 1'b1, "R6 fill");
        step(1'b0, 6'd20, 1'b0, "R6 long window holds");
        step(1'b1, 6'd5, 1'b1, "R6 shortened window opens");

        // R7: a window of 1 never withholds.
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 6'd1, 1'b1, "R7 unit window");

        // R8: window 63, blocked through cycle 62, free at 63, free after a long idle.
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b1, 6'd63, 1'b1, "R8 fill");
        for (int c = 4; c < 63; c++) step(1'b0, 6'd63, 1'b0, "R8 held");
        step(1'b0, 6'd63, 1'b1, "R8 free at window end");
        for (int c = 0; c < 300; c++) step(1'b0, 6'd63, 1'b1, "R8 idle across wrap");
        for (int i = 0; i < 4; i++) step(1'b1, 6'd63, 1'b1, "R8 refill");
        step(1'b1, 6'd63, 1'b0, "R1 fifth held after wrap");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule